// File: doc/BRIEF.md
# Horizontal Edge-Offset Sample Filter

This block applies the horizontal edge class of sample adaptive offset to one 8-bit luma block at a time. A `start` pulse latches the block geometry (`cfg_wd`, `cfg_ht`), the two picture-edge availability bits, five signed offsets and a five-entry category remap table. The block then consumes the block as a stream of beats. Each row arrives left to right, 16 samples per beat, and rows arrive top to bottom. Every input beat yields exactly one filtered output beat, in the same order. Each sample is compared with its left and right neighbours to get an edge category. The category is remapped and gated at the picture edges. It then selects an offset, which is added to the sample with saturation.

Each input beat also carries `in_next`, the sample just right of the last valid lane of that beat. No beat has to wait for its successor. When the block width leaves an 8-sample residue, the final beat of every row holds only 8 valid lanes. Three boundary stores are kept for the next block and can be read through `bnd_idx`: a left-column store (one entry per row), a top-row store (one entry per column) and a top-left corner register.

Both streams use valid/ready. An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. An output beat transfers where `out_valid` and `out_ready` are both high. A single output register sits between the streams. `in_ready` is low whenever that register is full and `out_ready` is low, so back-pressure reaches the source within the same cycle. A held output beat keeps its data unchanged until it is taken.

Top module: `sao_hedge_filter`

## Requirements
- R1: For each sample c with left neighbour l and right neighbour r, using unsigned compares, the raw category is 2 + (l>c) − (c>l) + (r>c) − (c>r), a value from 0 to 4.
- R2: The raw category k selects remap entry `remap_tbl[3k+2:3k]`. The gated result m then selects offset `ofs_tbl[8m+7:8m]`, read as two's complement. A value of m from 5 to 7 selects an offset of zero.
- R3: The output sample is c plus the sign-extended offset, saturated to the range 0..255.
- R4: The left neighbour of column 0 is the left-column store entry for that row. In later beats of a row, the left neighbour of lane 0 is lane 15 of the previous beat. The right neighbour of the last valid lane of a beat is `in_next`.
- R5: In column 0, the remapped value is forced to 0 when `avail_left` is 0. In column wd−1, it is forced to 0 when `avail_right` is 0. Otherwise the remapped value is used unchanged.
- R6: When wd−col equals 8 in a beat, only lanes 0..7 are valid. Lanes 8..15 of that input beat are ignored, lanes 8..15 of the output beat are zero, and the right-edge gating applies to lane 7.
- R7: At `start`, the corner register takes the top-row store entry wd−1 as it was before this block. It then holds that value until the next start.
- R8: After a block, the top-row store columns 0..wd−1 hold the unfiltered bottom row of that block. All other columns keep their previous values. Reset clears all stores.
- R9: After a block, the left-column store entry r holds the unfiltered sample at column wd−1 of row r, for every row r < ht.
- R10: `in_ready` is high only while `busy` is high and the output register is empty or being drained. While `out_valid` is high and `out_ready` is low, `out_data` stays stable.
- R11: `done` is a one-cycle pulse. It occurs in the cycle after the last input beat of the block is accepted, and `busy` is low in that same cycle. A `start` while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block, latching configuration (ignored while busy) |
| cfg_wd | input | 7 | Block width in samples, a multiple of 8, from 8 to 64 |
| cfg_ht | input | 7 | Block height in rows, from 1 to 64 |
| avail_left | input | 1 | Left picture-edge neighbour is usable |
| avail_right | input | 1 | Right picture-edge neighbour is usable |
| ofs_tbl | input | 40 | Five signed 8-bit offsets, entry m at bits 8m+7:8m |
| remap_tbl | input | 15 | Five 3-bit category remap entries, entry k at bits 3k+2:3k |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle when valid |
| in_data | input | 128 | 16 samples, lane i at bits 8i+7:8i |
| in_next | input | 8 | Sample right of the last valid lane of this beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink takes the output beat |
| out_data | output | 128 | Filtered samples, same lane layout |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse after the last input beat |
| bnd_idx | input | 6 | Read index for the boundary stores |
| bnd_top | output | 8 | Top-row store entry at bnd_idx |
| bnd_left | output | 8 | Left-column store entry at bnd_idx |
| bnd_corner | output | 8 | Top-left corner register |

## Verification
Corruption in the left-column store shows up only in column 0 of the following block. It is visible only when the left edge is available, so the directed blocks chain together with `avail_left` set, and the stores are also swept directly through `bnd_idx`. A wrong column or row counter shifts the edge gating or the residue handling onto the wrong lane. That error appears in the very first output beat of the affected row. A mistake in the output register's hold logic appears within one stalled cycle, as changed `out_data` under back-pressure. The comparison runs under stalls on every third cycle to expose it.

// File: rtl/sao_hedge_pkg.sv
package sao_hedge_pkg;
  localparam int NCAT  = 5;
  localparam int CAT_W = 3;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_t;
endpackage

// File: rtl/sao_hedge_lane.sv
module sao_hedge_lane
  import sao_hedge_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OFS_W = 8
) (
  input  logic [PIX_W-1:0]      l,
  input  logic [PIX_W-1:0]      c,
  input  logic [PIX_W-1:0]      r,
  input  logic                  keep,
  input  logic [NCAT*CAT_W-1:0] remap,
  input  logic [NCAT*OFS_W-1:0] ofs,
  output logic [PIX_W-1:0]      y
);
  localparam int SUM_W = ((PIX_W > OFS_W) ? PIX_W : OFS_W) + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic [CAT_W-1:0]        raw, mapped, sel;
  logic [OFS_W-1:0]        off;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    raw = CAT_W'(2) + CAT_W'(l > c) + CAT_W'(r > c) - CAT_W'(c > l) - CAT_W'(c > r);
    mapped = '0;
    for (int k = 0; k < NCAT; k++)
      if (raw == CAT_W'(k)) mapped = remap[k*CAT_W +: CAT_W];
    sel = keep ? mapped : '0;
    off = '0;
    for (int k = 0; k < NCAT; k++)
      if (sel == CAT_W'(k)) off = ofs[k*OFS_W +: OFS_W];
    sum = $signed({{(SUM_W-PIX_W){1'b0}}, c}) + $signed({{(SUM_W-OFS_W){off[OFS_W-1]}}, off});
    if (sum < 0)         y = '0;
    else if (sum > MAXV) y = '1;
    else                 y = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/sao_hedge_dp.sv
module sao_hedge_dp
  import sao_hedge_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OFS_W = 8,
  parameter int LANES = 16
) (
  input  logic [LANES*PIX_W-1:0] d,
  input  logic [PIX_W-1:0]       nxt,
  input  logic [PIX_W-1:0]       left_in,
  input  logic                   first_beat,
  input  logic                   last_in_row,
  input  logic                   resid,
  input  logic                   av_l,
  input  logic                   av_r,
  input  logic [NCAT*CAT_W-1:0]  remap,
  input  logic [NCAT*OFS_W-1:0]  ofs,
  output logic [LANES*PIX_W-1:0] y
);
  localparam int HALF = LANES / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_ln
    logic [PIX_W-1:0] lft, rgt, f;
    logic kl, kr, live;

    if (i == 0) begin : g_l0
      assign lft = left_in;
      assign kl  = ~(first_beat & ~av_l);
    end else begin : g_ln
      assign lft = d[(i-1)*PIX_W +: PIX_W];
      assign kl  = 1'b1;
    end

    if (i == LANES-1) begin : g_rlast
      assign rgt = nxt;
      assign kr  = ~(last_in_row & ~resid & ~av_r);
    end else if (i == HALF-1) begin : g_rhalf
      assign rgt = resid ? nxt : d[(i+1)*PIX_W +: PIX_W];
      assign kr  = ~(last_in_row & resid & ~av_r);
    end else begin : g_rmid
      assign rgt = d[(i+1)*PIX_W +: PIX_W];
      assign kr  = 1'b1;
    end

    if (i >= HALF) begin : g_hi
      assign live = ~resid;
    end else begin : g_lo
      assign live = 1'b1;
    end

    sao_hedge_lane #(.PIX_W(PIX_W), .OFS_W(OFS_W)) i_lane (
      .l(lft), .c(d[i*PIX_W +: PIX_W]), .r(rgt), .keep(kl & kr),
      .remap(remap), .ofs(ofs), .y(f)
    );

    assign y[i*PIX_W +: PIX_W] = live ? f : '0;
  end
endmodule

// File: rtl/sao_hedge_ctrl.sv
module sao_hedge_ctrl
  import sao_hedge_pkg::*;
#(
  parameter int LANES = 16,
  parameter int WD_W  = 7,
  parameter int HT_W  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WD_W-1:0] cfg_wd,
  input  logic [HT_W-1:0] cfg_ht,
  input  logic            fire,
  output logic            cap,
  output logic            busy,
  output logic            first_beat,
  output logic            last_in_row,
  output logic            resid,
  output logic            bottom_row,
  output logic [WD_W-1:0] col,
  output logic [HT_W-1:0] row,
  output logic            done
);
  st_t             st_q;
  logic [WD_W-1:0] wd_q, col_q, remain;
  logic [HT_W-1:0] ht_q, row_q;
  logic            done_q;

  assign cap         = (st_q == ST_IDLE) && start;
  assign busy        = (st_q == ST_RUN);
  assign remain      = wd_q - col_q;
  assign first_beat  = (col_q == '0);
  assign last_in_row = (remain <= WD_W'(LANES));
  assign resid       = (remain < WD_W'(LANES));
  assign bottom_row  = (row_q == ht_q - HT_W'(1));
  assign col         = col_q;
  assign row         = row_q;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wd_q   <= '0;
      ht_q   <= '0;
      col_q  <= '0;
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cap) begin
        st_q  <= ST_RUN;
        wd_q  <= cfg_wd;
        ht_q  <= cfg_ht;
        col_q <= '0;
        row_q <= '0;
      end else if (busy && fire) begin
        if (last_in_row) begin
          col_q <= '0;
          if (bottom_row) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            row_q <= row_q + HT_W'(1);
          end
        end else begin
          col_q <= col_q + WD_W'(LANES);
        end
      end
    end
  end
endmodule

// File: rtl/sao_hedge_bnd.sv
module sao_hedge_bnd #(
  parameter int PIX_W  = 8,
  parameter int LANES  = 16,
  parameter int MAX_WD = 64,
  parameter int MAX_HT = 64,
  parameter int WD_W   = 7,
  parameter int HT_W   = 7,
  parameter int BI_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap,
  input  logic [WD_W-1:0]        cap_wd,
  input  logic                   fire,
  input  logic                   bottom_row,
  input  logic                   last_in_row,
  input  logic                   resid,
  input  logic [WD_W-1:0]        col,
  input  logic [HT_W-1:0]        row,
  input  logic [LANES*PIX_W-1:0] d,
  input  logic [BI_W-1:0]        rd_idx,
  output logic [PIX_W-1:0]       left_rd,
  output logic [PIX_W-1:0]       top_o,
  output logic [PIX_W-1:0]       left_o,
  output logic [PIX_W-1:0]       corner_o
);
  localparam int HALF = LANES / 2;
  localparam int TI_W = $clog2(MAX_WD);
  localparam int LI_W = $clog2(MAX_HT);

  logic [PIX_W-1:0] top_q  [MAX_WD];
  logic [PIX_W-1:0] left_q [MAX_HT];
  logic [PIX_W-1:0] corner_q;

  assign left_rd  = left_q[LI_W'(row)];
  assign top_o    = top_q[TI_W'(rd_idx)];
  assign left_o   = left_q[LI_W'(rd_idx)];
  assign corner_o = corner_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MAX_WD; j++) top_q[j] <= '0;
      for (int j = 0; j < MAX_HT; j++) left_q[j] <= '0;
      corner_q <= '0;
    end else begin
      if (cap) corner_q <= top_q[TI_W'(cap_wd - WD_W'(1))];
      if (fire && bottom_row) begin
        for (int i = 0; i < LANES; i++)
          if (!(resid && i >= HALF))
            top_q[TI_W'(int'(col) + i)] <= d[i*PIX_W +: PIX_W];
      end
      if (fire && last_in_row)
        left_q[LI_W'(row)] <= resid ? d[(HALF-1)*PIX_W +: PIX_W] : d[(LANES-1)*PIX_W +: PIX_W];
    end
  end
endmodule

// File: rtl/sao_hedge_filter.sv
module sao_hedge_filter
  import sao_hedge_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int OFS_W  = 8,
  parameter int LANES  = 16,
  parameter int MAX_WD = 64,
  parameter int MAX_HT = 64,
  localparam int WD_W  = $clog2(MAX_WD + 1),
  localparam int HT_W  = $clog2(MAX_HT + 1),
  localparam int BI_W  = $clog2((MAX_WD > MAX_HT) ? MAX_WD : MAX_HT),
  localparam int DW    = LANES * PIX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [WD_W-1:0]       cfg_wd,
  input  logic [HT_W-1:0]       cfg_ht,
  input  logic                  avail_left,
  input  logic                  avail_right,
  input  logic [NCAT*OFS_W-1:0] ofs_tbl,
  input  logic [NCAT*CAT_W-1:0] remap_tbl,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW-1:0]         in_data,
  input  logic [PIX_W-1:0]      in_next,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DW-1:0]         out_data,
  output logic                  busy,
  output logic                  done,
  input  logic [BI_W-1:0]       bnd_idx,
  output logic [PIX_W-1:0]      bnd_top,
  output logic [PIX_W-1:0]      bnd_left,
  output logic [PIX_W-1:0]      bnd_corner
);
  logic                  cap, fire, first_beat, last_in_row, resid, bottom_row;
  logic [WD_W-1:0]       col;
  logic [HT_W-1:0]       row;
  logic [PIX_W-1:0]      left_rd, prev_q, left_in;
  logic                  av_l_q, av_r_q, ov_q;
  logic [NCAT*OFS_W-1:0] ofs_q;
  logic [NCAT*CAT_W-1:0] remap_q;
  logic [DW-1:0]         y, od_q;

  assign in_ready  = busy && (!ov_q || out_ready);
  assign fire      = in_valid && in_ready;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign left_in   = first_beat ? left_rd : prev_q;

  sao_hedge_ctrl #(.LANES(LANES), .WD_W(WD_W), .HT_W(HT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_wd(cfg_wd), .cfg_ht(cfg_ht),
    .fire(fire), .cap(cap), .busy(busy), .first_beat(first_beat),
    .last_in_row(last_in_row), .resid(resid), .bottom_row(bottom_row),
    .col(col), .row(row), .done(done)
  );

  sao_hedge_dp #(.PIX_W(PIX_W), .OFS_W(OFS_W), .LANES(LANES)) i_dp (
    .d(in_data), .nxt(in_next), .left_in(left_in), .first_beat(first_beat),
    .last_in_row(last_in_row), .resid(resid), .av_l(av_l_q), .av_r(av_r_q),
    .remap(remap_q), .ofs(ofs_q), .y(y)
  );

  sao_hedge_bnd #(.PIX_W(PIX_W), .LANES(LANES), .MAX_WD(MAX_WD), .MAX_HT(MAX_HT),
                  .WD_W(WD_W), .HT_W(HT_W), .BI_W(BI_W)) i_bnd (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_wd(cfg_wd), .fire(fire),
    .bottom_row(bottom_row), .last_in_row(last_in_row), .resid(resid),
    .col(col), .row(row), .d(in_data), .rd_idx(bnd_idx), .left_rd(left_rd),
    .top_o(bnd_top), .left_o(bnd_left), .corner_o(bnd_corner)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      av_l_q  <= 1'b0;
      av_r_q  <= 1'b0;
      ofs_q   <= '0;
      remap_q <= '0;
      prev_q  <= '0;
      ov_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      if (cap) begin
        av_l_q  <= avail_left;
        av_r_q  <= avail_right;
        ofs_q   <= ofs_tbl;
        remap_q <= remap_tbl;
      end
      if (fire) begin
        prev_q <= in_data[(LANES-1)*PIX_W +: PIX_W];
        od_q   <= y;
        ov_q   <= 1'b1;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sao_hedge_chk.sv
module sao_hedge_chk #(
  parameter int DW  = 128,
  parameter int PW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [PW-1:0] bnd_corner
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r10_idle_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && out_valid);

  a_r7_corner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(bnd_corner));
endmodule

bind sao_hedge_filter sao_hedge_chk #(.DW(LANES*PIX_W), .PW(PIX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .bnd_corner(bnd_corner)
);

// File: tb/test_sao_hedge_filter.sv
module test_sao_hedge_filter;
  localparam int LANES = 16;
  localparam int MW = 64;
  localparam int MH = 64;
  localparam int DW = LANES * 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] cfg_wd = '0, cfg_ht = '0;
  logic avail_left = 1'b0, avail_right = 1'b0;
  logic [39:0] ofs_tbl = '0;
  logic [14:0] remap_tbl = '0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, busy, done;
  logic [DW-1:0] in_data = '0, out_data;
  logic [7:0] in_next = '0, bnd_top, bnd_left, bnd_corner;
  logic [5:0] bnd_idx = '0;

  int n_chk = 0, n_fail = 0;
  int pix [MH][MW];
  int pix_r [MH];
  int m_top [MW];
  int m_left [MH];
  int m_corner = 0;
  int ofs [5];
  int rmp [5];

  always #10 clk = ~clk;

  sao_hedge_filter i_sao_hedge_filter (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_wd(cfg_wd), .cfg_ht(cfg_ht),
    .avail_left(avail_left), .avail_right(avail_right), .ofs_tbl(ofs_tbl),
    .remap_tbl(remap_tbl), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_next(in_next), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .busy(busy), .done(done),
    .bnd_idx(bnd_idx), .bnd_top(bnd_top), .bnd_left(bnd_left),
    .bnd_corner(bnd_corner)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int sgn(input int a, input int b);
    return (a > b) ? 1 : ((a < b) ? -1 : 0);
  endfunction

  // reference per R1..R5
  function automatic int ref_pix(input int r, input int c, input int wd, input int al, input int ar);
    int cur, lf, rt, k, m, v;
    cur = pix[r][c];
    lf  = (c == 0) ? m_left[r] : pix[r][c-1];
    rt  = (c == wd-1) ? pix_r[r] : pix[r][c+1];
    k   = 2 + sgn(lf, cur) + sgn(rt, cur);
    m   = rmp[k];
    if (c == 0 && al == 0) m = 0;
    if (c == wd-1 && ar == 0) m = 0;
    v = cur + ((m < 5) ? ofs[m] : 0);
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic fill(input int wd, input int ht, input int mode);
    for (int r = 0; r < ht; r++) begin
      for (int c = 0; c <= wd; c++) begin
        int v;
        case (mode)
          1: v = ($urandom_range(0, 1) == 1) ? 255 - $urandom_range(0, 1) : $urandom_range(0, 1);
          2: v = 100 + $urandom_range(0, 2);
          default: v = $urandom_range(0, 255);
        endcase
        if (c == wd) pix_r[r] = v; else pix[r][c] = v;
      end
    end
  endtask

  task automatic check_bnd(input string tag, input int ht);
    @(negedge clk);
    chk(bnd_corner == 8'(m_corner), {tag, " R7 corner"}, bnd_corner, m_corner);
    for (int j = 0; j < MW; j++) begin
      bnd_idx = 6'(j);
      #1;
      chk(bnd_top == 8'(m_top[j]), $sformatf("%s R8 top[%0d]", tag, j), bnd_top, m_top[j]);
      chk(bnd_left == 8'(m_left[j]), $sformatf("%s R9 left[%0d] ht=%0d", tag, j, ht), bnd_left, m_left[j]);
    end
  endtask

  // Drive one block, compare every output beat, then update the boundary model
  task automatic run_block(input string tag, input int wd, input int ht, input int al,
                           input int ar, input int stall, input int poke, input int mode);
    int nb, total, ib, ob, cyc, dones;
    fill(wd, ht, mode);
    nb = (wd + LANES - 1) / LANES;
    total = nb * ht;
    for (int k = 0; k < 5; k++) begin
      ofs_tbl[k*8 +: 8]   = 8'(ofs[k]);
      remap_tbl[k*3 +: 3] = 3'(rmp[k]);
    end
    @(negedge clk);
    cfg_wd = 7'(wd); cfg_ht = 7'(ht);
    avail_left = al[0]; avail_right = ar[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: a start while busy must not reconfigure
    cfg_wd = 7'(8); cfg_ht = 7'(1); avail_left = ~al[0]; avail_right = ~ar[0];
    ib = 0; ob = 0; cyc = 0; dones = 0;
    while (ob < total && cyc < 4000) begin
      out_ready = (stall != 0) ? (cyc % 3 != 2) : 1'b1;
      start = (poke != 0 && cyc == 2);
      if (ib < total) begin
        int r, c;
        r = ib / nb; c = (ib % nb) * LANES;
        in_valid = 1'b1;
        for (int i = 0; i < LANES; i++)
          in_data[i*8 +: 8] = (c + i < wd) ? 8'(pix[r][c+i]) : 8'hA5;  // R6 junk lanes
        in_next = (c + LANES < wd) ? 8'(pix[r][c+LANES]) : 8'(pix_r[r]);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (done) dones++;
      if (out_valid && out_ready) begin
        int r, c;
        logic [DW-1:0] e;
        r = ob / nb; c = (ob % nb) * LANES;
        for (int i = 0; i < LANES; i++)
          e[i*8 +: 8] = (c + i < wd) ? 8'(ref_pix(r, c + i, wd, al, ar)) : 8'h00;
        n_chk++;
        if (out_data !== e) begin
          n_fail++;
          $display("FAIL %s R1/R2/R3/R4/R5/R6 beat %0d row %0d col %0d actual=%h expected=%h",
                   tag, ob, r, c, out_data, e);
        end
        ob++;
      end
      if (in_valid && in_ready) ib++;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0; out_ready = 1'b1; start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      if (done) dones++;
      @(negedge clk);
    end
    chk(ob == total, {tag, " R10 beat count"}, ob, total);
    chk(dones == 1, {tag, " R11 single done"}, dones, 1);
    chk(busy == 1'b0, {tag, " R11 idle after"}, busy, 0);
    m_corner = m_top[wd-1];
    for (int c = 0; c < wd; c++) m_top[c] = pix[ht-1][c];
    for (int r = 0; r < ht; r++) m_left[r] = pix[r][wd-1];
    check_bnd(tag, ht);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 1'b0, "R11 reset busy", busy, 0);
    chk(in_ready == 1'b0, "R10 reset in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    for (int j = 0; j < MW; j++) begin m_top[j] = 0; m_left[j] = 0; end
    check_bnd("reset", 0);
  endtask

  task automatic t_full_rows;
    rmp = '{1, 2, 0, 3, 4};
    ofs = '{0, 6, 2, -2, -6};
    run_block("full_rows", 48, 4, 1, 1, 0, 0, 0);
  endtask

  task automatic t_residue_gated;
    rmp = '{1, 2, 0, 3, 4};
    ofs = '{0, 9, 4, -4, -9};
    run_block("residue_gated", 24, 5, 0, 0, 1, 1, 2);
  endtask

  task automatic t_clip;
    rmp = '{0, 1, 2, 3, 4};
    ofs = '{0, 127, 127, -128, -128};
    run_block("clip_extremes", 32, 3, 1, 1, 0, 0, 1);
  endtask

  task automatic t_narrow_remap;
    rmp = '{7, 1, 2, 3, 6};
    ofs = '{5, -1, 9, -9, 1};
    run_block("narrow_remap", 8, 2, 1, 0, 1, 0, 2);
  endtask

  task automatic t_wide_stall;
    rmp = '{1, 2, 0, 3, 4};
    ofs = '{0, 3, 1, -1, -3};
    run_block("wide_stall", 64, 6, 1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_rows();
    t_residue_gated();
    t_clip();
    t_narrow_remap();
    t_wide_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired R10 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule